// File: doc/BRIEF.md
# Per-Output Earliest-Departure Selector

This block sits on the egress side of a switch whose every output port is fed by several parallel output queues. In each slot the switch may send only one cell off each output port. Every queue reports three things about its head cell: whether a cell is present, the slot in which that cell is due to leave, and its priority class. From these reports the block chooses the single queue per output that may send its head cell. The queues themselves, the arrival-side scheduling and the line interface are outside this block.

The choice is strict priority first and earliest departure second. Class and time-to-leave are joined into one comparison key, with class in the upper bits. A single minimum search over each output's queues therefore does both jobs. All outputs are searched side by side. The result for each output is registered at the slot boundary, so a grant appears one clock after the queue reports that produced it. Each clock edge is one slot.

Top module: `dep_selector`

## Requirements
- R1: While `rst` is high at a clock edge, every grant-valid bit, one-hot bit and index bit is cleared at that edge.
- R2: For each output, the registered one-hot grant vector has at most one bit set.
- R3: A queue whose valid bit is 0 is never granted. If no queue of an output is valid, that output's grant-valid bit, one-hot vector and index are all 0.
- R4: Among valid queues of the same class, the queue with the smallest time-to-leave is granted. Time-to-leave is compared as an unsigned number.
- R5: Class precedes time-to-leave strictly. Class code 0 is the highest class and code 3 the lowest. A valid queue with a lower class code wins over any queue with a higher code, whatever their time-to-leave values.
- R6: When several valid queues share the smallest {class, time-to-leave} key, the queue with the lowest index is granted.
- R7: The grant-valid bit, one-hot vector and index reflect the queue reports sampled at the previous clock edge. They do not change between edges. When the grant is valid, the index equals the position of the set one-hot bit.
- R8: Each output's grant depends only on its own queues' reports. Queue j of output o uses flat position q = o*M + j.
    - Its time-to-leave is `q_tl[q*TL_W +: TL_W]`.
    - Its class is `q_cls[q*2 +: 2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | N_OUT*M_Q | Head cell present, one bit per queue, flat index o*M_Q+j |
| q_tl | input | N_OUT*M_Q*TL_W | Head cell time-to-leave per queue |
| q_cls | input | N_OUT*M_Q*2 | Head cell class per queue, 0 highest |
| gnt_vld | output | N_OUT | A departure is granted for this output |
| gnt_onehot | output | N_OUT*M_Q | Granted queue of each output as a one-hot slice |
| gnt_idx | output | N_OUT*IDX_W | Granted queue of each output as an encoded index |

## Verification
The search is tried with these input patterns:
- A single class with distinct time-to-leave values shows that the minimum is picked rather than a fixed position.
- Placing the smallest time-to-leave on an invalid queue separates masking from plain comparison.
- A mix of classes in which the best class carries the largest time-to-leave shows that class dominates.
- Equal keys across all or some queues separate the lowest-index rule from any other tie order.
- Running all four outputs with different patterns in the same slot, and holding new inputs between edges, shows that rows are independent and that the output is registered.

// File: rtl/dep_sel_pkg.sv
package dep_sel_pkg;
  localparam int CLS_W = 2;

  function automatic int idx_width(input int m);
    return (m > 1) ? $clog2(m) : 1;
  endfunction
endpackage

// File: rtl/dep_row_pick.sv
module dep_row_pick #(
  parameter int M     = 4,
  parameter int KEY_W = 10,
  parameter int IDX_W = 2
) (
  input  logic [M-1:0]       valid,
  input  logic [M*KEY_W-1:0] keys,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  logic [KEY_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int j = 0; j < M; j++) begin
      if (valid[j] && (!found || keys[j*KEY_W +: KEY_W] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(j);
        best  = keys[j*KEY_W +: KEY_W];
      end
    end
  end
endmodule

// File: rtl/dep_grant_reg.sv
module dep_grant_reg #(
  parameter int M     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             found,
  input  logic [IDX_W-1:0] idx,
  output logic             vld_q,
  output logic [M-1:0]     onehot_q,
  output logic [IDX_W-1:0] idx_q
);
  logic [M-1:0] onehot_d;

  always_comb begin
    onehot_d = '0;
    if (found) onehot_d[idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= 1'b0;
      onehot_q <= '0;
      idx_q    <= '0;
    end else begin
      vld_q    <= found;
      onehot_q <= onehot_d;
      idx_q    <= found ? idx : '0;
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(onehot_q));
  a_r7_vld_matches_vec: assert property (@(posedge clk) disable iff (rst) vld_q == (|onehot_q));
  a_r7_idx_points_bit: assert property (@(posedge clk) disable iff (rst) vld_q |-> onehot_q[idx_q]);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!vld_q && onehot_q == '0 && idx_q == '0));
endmodule

// File: rtl/dep_selector.sv
module dep_selector
  import dep_sel_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int M_Q   = 4,
  parameter int TL_W  = 8,
  parameter int IDX_W = idx_width(M_Q)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_OUT*M_Q-1:0]      q_valid,
  input  logic [N_OUT*M_Q*TL_W-1:0] q_tl,
  input  logic [N_OUT*M_Q*2-1:0]    q_cls,
  output logic [N_OUT-1:0]          gnt_vld,
  output logic [N_OUT*M_Q-1:0]      gnt_onehot,
  output logic [N_OUT*IDX_W-1:0]    gnt_idx
);
  localparam int KEY_W = CLS_W + TL_W;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [M_Q*KEY_W-1:0] row_keys;
    logic                 pick_found;
    logic [IDX_W-1:0]     pick_idx;
    logic [KEY_W-1:0]     pick_key;

    for (genvar j = 0; j < M_Q; j++) begin : g_key
      localparam int Q = o*M_Q + j;
      assign row_keys[j*KEY_W +: KEY_W] = {q_cls[Q*CLS_W +: CLS_W], q_tl[Q*TL_W +: TL_W]};
    end

    dep_row_pick #(.M(M_Q), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_pick (
      .valid (q_valid[o*M_Q +: M_Q]),
      .keys  (row_keys),
      .found (pick_found),
      .idx   (pick_idx)
    );

    dep_grant_reg #(.M(M_Q), .IDX_W(IDX_W)) u_reg (
      .clk      (clk),
      .rst      (rst),
      .found    (pick_found),
      .idx      (pick_idx),
      .vld_q    (gnt_vld[o]),
      .onehot_q (gnt_onehot[o*M_Q +: M_Q]),
      .idx_q    (gnt_idx[o*IDX_W +: IDX_W])
    );

    assign pick_key = row_keys[pick_idx*KEY_W +: KEY_W];

    // R3: an empty row yields no grant, a non-empty row always yields one
    a_r3_found_iff_any: assert property (@(posedge clk) disable iff (rst)
      pick_found == (|q_valid[o*M_Q +: M_Q]));
    a_r3_winner_valid: assert property (@(posedge clk) disable iff (rst)
      pick_found |-> q_valid[o*M_Q + pick_idx]);

    for (genvar j = 0; j < M_Q; j++) begin : g_chk
      // R4/R5: the winning key is no larger than any valid key of the row
      a_r4_min_key: assert property (@(posedge clk) disable iff (rst)
        (pick_found && q_valid[o*M_Q+j]) |-> (pick_key <= row_keys[j*KEY_W +: KEY_W]));
      // R6: an equal key never sits at a lower index than the winner
      a_r6_low_index: assert property (@(posedge clk) disable iff (rst)
        (pick_found && q_valid[o*M_Q+j] && row_keys[j*KEY_W +: KEY_W] == pick_key)
          |-> (int'(pick_idx) <= j));
    end
  end
endmodule

// File: tb/dep_selector_test.sv
module dep_selector_test;
  localparam int N = 4;
  localparam int M = 4;
  localparam int TW = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*M-1:0]    q_valid = '0;
  logic [N*M*TW-1:0] q_tl = '0;
  logic [N*M*2-1:0]  q_cls = '0;
  logic [N-1:0]      gnt_vld;
  logic [N*M-1:0]    gnt_onehot;
  logic [N*IW-1:0]   gnt_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dep_selector #(.N_OUT(N), .M_Q(M), .TL_W(TW)) uut (
    .clk(clk), .rst(rst), .q_valid(q_valid), .q_tl(q_tl), .q_cls(q_cls),
    .gnt_vld(gnt_vld), .gnt_onehot(gnt_onehot), .gnt_idx(gnt_idx)
  );

  task automatic set_q(input int o, input int j, input bit v, input int cls, input int tl);
    q_valid[o*M+j]          = v;
    q_cls[(o*M+j)*2 +: 2]   = 2'(cls);
    q_tl[(o*M+j)*TW +: TW]  = TW'(tl);
  endtask

  task automatic clear_all();
    q_valid = '0; q_tl = '0; q_cls = '0;
  endtask

  task automatic check_out(input int o, input bit ev, input int eidx, input string req);
    logic [M-1:0]  eoh;
    logic [IW-1:0] ei;
    eoh = ev ? (M'(1) << eidx) : '0;
    ei  = ev ? IW'(eidx) : '0;
    checks++;
    if (gnt_vld[o] !== ev || gnt_onehot[o*M +: M] !== eoh || gnt_idx[o*IW +: IW] !== ei) begin
      errors++;
      $display("FAIL %s out%0d: vld=%b oh=%b idx=%0d expected vld=%b oh=%b idx=%0d",
               req, o, gnt_vld[o], gnt_onehot[o*M +: M], gnt_idx[o*IW +: IW], ev, eoh, ei);
    end
  endtask

  task automatic t_reset();
    for (int q = 0; q < N*M; q++) set_q(q / M, q % M, 1'b1, 0, q);
    @(negedge clk);
    for (int o = 0; o < N; o++) check_out(o, 1'b0, 0, "R1");
    rst = 1'b0;
  endtask

  task automatic t_empty();
    @(negedge clk); clear_all();
    @(negedge clk);
    for (int o = 0; o < N; o++) check_out(o, 1'b0, 0, "R3");
  endtask

  task automatic t_earliest();
    @(negedge clk); clear_all();
    set_q(0,0,1,0,50); set_q(0,1,1,0,20); set_q(0,2,1,0,30); set_q(0,3,1,0,40);
    set_q(1,0,1,0,9);  set_q(1,1,0,0,3);  set_q(1,2,1,0,7);  set_q(1,3,1,0,8);
    set_q(2,0,1,1,255); set_q(2,3,1,1,0);
    @(negedge clk);
    check_out(0, 1'b1, 1, "R4");
    check_out(1, 1'b1, 2, "R3");
    check_out(2, 1'b1, 3, "R4");
    check_out(3, 1'b0, 0, "R3");
  endtask

  task automatic t_class();
    @(negedge clk); clear_all();
    set_q(2,0,1,3,1); set_q(2,1,1,1,200); set_q(2,2,1,2,0); set_q(2,3,1,1,250);
    set_q(0,0,1,3,0); set_q(0,1,1,3,0); set_q(0,2,1,0,255); set_q(0,3,1,2,0);
    @(negedge clk);
    check_out(2, 1'b1, 1, "R5");
    check_out(0, 1'b1, 2, "R5");
  endtask

  task automatic t_tie();
    @(negedge clk); clear_all();
    for (int j = 0; j < M; j++) set_q(3, j, 1'b1, 2, 5);
    set_q(1,0,0,0,5); set_q(1,1,1,0,5); set_q(1,2,1,0,5); set_q(1,3,1,0,5);
    @(negedge clk);
    check_out(3, 1'b1, 0, "R6");
    check_out(1, 1'b1, 1, "R6");
  endtask

  task automatic t_indep();
    @(negedge clk); clear_all();
    set_q(0,3,1,0,1);
    set_q(1,0,1,2,9); set_q(1,2,1,1,100);
    set_q(2,1,1,0,4); set_q(2,2,1,0,4);
    set_q(3,0,1,0,0);
    @(negedge clk);
    check_out(0, 1'b1, 3, "R8");
    check_out(1, 1'b1, 2, "R8");
    check_out(2, 1'b1, 1, "R8");
    check_out(3, 1'b1, 0, "R8");
  endtask

  task automatic t_latency();
    @(negedge clk); clear_all();
    set_q(0,2,1,0,10);
    @(negedge clk);
    check_out(0, 1'b1, 2, "R7");
    clear_all();
    set_q(0,0,1,0,3);
    #1;
    check_out(0, 1'b1, 2, "R7");
    @(negedge clk);
    check_out(0, 1'b1, 0, "R7");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_empty();
    t_earliest();
    t_class();
    t_tie();
    t_indep();
    t_latency();
    finish_run();
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule